// File: doc/BRIEF.md
# Flagged FIFO with Read Rewind

This block is a first-in first-out buffer of 512 words, each 9 bits wide. Write and read pointers inside the block walk through the storage on their own, so a user only raises a write strobe with data or a read strobe and picks the word up on the output bus. The ninth bit is an ordinary data bit. It is typically used for parity or a control marker, and it is stored and returned exactly like the other eight.

Three active-low flags report the fill level: empty, full, and more-than-half-full. A write into a full buffer is dropped, and so is a read from an empty one. A rewind input puts the read pointer back at the first location, so every word written since reset can be read out again. After a rewind the fill level is recomputed from the write pointer.

All strobes are sampled on the rising edge of one clock. Reset is asynchronous and active low.

Top module: `rt_fifo`

## Requirements
- R1: Words come out in the order they were written, with all 9 bits unchanged, bit 8 included.
- R2: While rst_ni is low: empty_no is 0, full_no is 1, half_no is 1 and rd_data_o is 0. Strobes applied during reset have no effect, so the buffer is still empty after reset is released.
- R3: A read strobe while the buffer is empty is dropped, and rd_data_o and the flags do not change. A write strobe while the buffer holds 512 words is dropped, so the stored data and the fill level do not change.
- R4: A rewind (rt_i high at a clock edge) moves the read position to the first word written since reset. The fill level becomes the number of words written since reset, and the flags follow it. A rewind is valid only if fewer than 512 words have been written since reset.
- R5: empty_no is 0 exactly when the fill level is 0. It rises on the edge that accepts a write into an empty buffer and falls on the edge that reads out the last word.
- R6: full_no is 0 exactly when the fill level is 512. It falls on the edge that accepts the 512th word and rises on the edge that accepts a read from a full buffer.
- R7: half_no is 0 exactly when the fill level is 257 or more, and 1 when the fill level is 256 or less.
- R8: A write and a read in the same cycle are both carried out when the buffer is neither empty nor full. The fill level does not change and order is kept. If the buffer is empty, only the write is carried out; if it is full, only the read is carried out.
- R9: rd_data_o is registered. It changes only on the clock edge that accepts a read, and it holds the last word read until the next accepted read.
- R10: When rt_i is high, any write or read strobe in the same cycle is ignored.
- R11: The flags and rd_data_o reflect a strobe on the first rising clock edge after it is presented. No further cycles of latency are added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rt_i | input | 1 | Rewind the read position to the first word |
| wr_data_i | input | 9 | Write data |
| rd_data_o | output | 9 | Registered read data |
| empty_no | output | 1 | Low when the buffer holds no words |
| full_no | output | 1 | Low when the buffer holds 512 words |
| half_no | output | 1 | Low when the buffer holds more than 256 words |

## Verification
Every strobe, including a rewind, updates the flags and the read data on the rising edge that samples it. The bench drives inputs on the falling edge and compares all four outputs on the next falling edge, so each check lands exactly one edge after its stimulus. Reset acts at once, so the reset flag values are checked while rst_ni is still low, with strobes held high at the same time. A cycle-level queue model in the bench, which keeps every word written since reset, supplies the expected data and fill level, including after a rewind.

// File: rtl/rt_fifo_pkg.sv
package rt_fifo_pkg;
  typedef struct packed {
    logic empty_n;
    logic full_n;
    logic half_n;
  } flags_t;
endpackage

// File: rtl/rt_fifo_ctrl.sv
module rt_fifo_ctrl #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          rt_i,
  output logic          wr_en_o,
  output logic          rd_en_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [CW-1:0] count_o
);
  logic is_empty, is_full;

  assign is_empty = (count_o == '0);
  assign is_full  = (count_o == CW'(DEPTH));
  // rewind wins over both strobes
  assign wr_en_o  = wr_i && !rt_i && !is_full;
  assign rd_en_o  = rd_i && !rt_i && !is_empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_o <= '0;
      rd_ptr_o <= '0;
      count_o  <= '0;
    end else if (rt_i) begin
      rd_ptr_o <= '0;
      count_o  <= CW'(wr_ptr_o);
    end else begin
      if (wr_en_o) wr_ptr_o <= bump(wr_ptr_o);
      if (rd_en_o) rd_ptr_o <= bump(rd_ptr_o);
      case ({wr_en_o, rd_en_o})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_full && wr_i && !rd_i && !rt_i) |=> (count_o == CW'(DEPTH)) && $stable(wr_ptr_o));

  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_empty && rd_i && !wr_i && !rt_i) |=> (count_o == '0) && $stable(rd_ptr_o));

  assert_rewind_R4_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_i |=> (rd_ptr_o == '0) && $stable(wr_ptr_o));

  assert_balanced_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i && !rt_i && !is_empty && !is_full) |=> $stable(count_o));
endmodule

// File: rtl/rt_fifo_flags.sv
module rt_fifo_flags
  import rt_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int CW = $clog2(DEPTH) + 1,
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  output flags_t        flags_o
);
  assign flags_o.empty_n = (count_i != '0);
  assign flags_o.full_n  = (count_i != CW'(DEPTH));
  assign flags_o.half_n  = (count_i <= CW'(HALF));

  assert_full_has_half_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_o.full_n |-> !flags_o.half_n);

  assert_full_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o.full_n) |-> (count_i == CW'(DEPTH - 1)));
endmodule

// File: rtl/rt_fifo_mem.sv
module rt_fifo_mem #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] store_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) store_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= store_q[rd_addr_i];
  end

  assert_dout_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/rt_fifo.sv
module rt_fifo
  import rt_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             rt_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             empty_no,
  output logic             full_no,
  output logic             half_no
);
  logic          wr_en, rd_en;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  flags_t        flags;

  rt_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .rt_i     (rt_i),
    .wr_en_o  (wr_en),
    .rd_en_o  (rd_en),
    .wr_ptr_o (wr_ptr),
    .rd_ptr_o (rd_ptr),
    .count_o  (count)
  );

  rt_fifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_ptr),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_ptr),
    .rd_data_o (rd_data_o)
  );

  rt_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_i (count),
    .flags_o (flags)
  );

  assign empty_no = flags.empty_n;
  assign full_no  = flags.full_n;
  assign half_no  = flags.half_n;

  assert_reset_flags_R2: assert property (@(posedge clk_i)
    !rst_ni |-> (!empty_no && full_no && half_no && rd_data_o == '0));
endmodule

// File: tb/rt_fifo_bench.sv
module rt_fifo_bench;
  localparam int DEPTH = 512;
  localparam int HALF  = DEPTH / 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0, rt_i = 1'b0;
  logic [8:0] wr_data_i = '0;
  logic [8:0] rd_data_o;
  logic       empty_no, full_no, half_no;

  int checks = 0;
  int fails  = 0;

  // model: every word written since reset, read index, write index
  logic [8:0] hist[$];
  int         rd_idx = 0;
  int         wr_idx = 0;
  logic [8:0] exp_dout = '0;

  always #2 clk = ~clk;

  rt_fifo u_rt_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .rt_i(rt_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .empty_no(empty_no), .full_no(full_no), .half_no(half_no)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic chk(string tag);
    int   cnt;
    logic [11:0] act, exp;
    cnt = wr_idx - rd_idx;
    exp = {cnt != 0, cnt != DEPTH, cnt <= HALF, exp_dout};
    act = {empty_no, full_no, half_no, rd_data_o};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {empty_n,full_n,half_n,dout} actual=%b_%h expected=%b_%h (level %0d)",
               tag, act[11:9], act[8:0], exp[11:9], exp[8:0], cnt);
    end
  endtask

  // one cycle: drive at falling edge, model at rising edge, check at next falling edge (R11)
  task automatic cyc(input logic w, input logic r, input logic t, input logic [8:0] d, input string tag);
    int cnt;
    wr_i = w; rd_i = r; rt_i = t; wr_data_i = d;
    @(posedge clk);
    cnt = wr_idx - rd_idx;
    if (t) rd_idx = 0;
    else begin
      if (r && cnt > 0) begin exp_dout = hist[rd_idx]; rd_idx++; end
      if (w && cnt < DEPTH) begin hist.push_back(d); wr_idx++; end
    end
    @(negedge clk);
    wr_i = 1'b0; rd_i = 1'b0; rt_i = 1'b0;
    chk(tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_ni = 1'b0; wr_i = 1'b1; rd_i = 1'b1; wr_data_i = 9'h1aa;
    hist.delete(); rd_idx = 0; wr_idx = 0; exp_dout = '0;
    #1 chk("R2 flags during reset");
    repeat (2) @(negedge clk);
    chk("R2 strobes held in reset");
    wr_i = 1'b0; rd_i = 1'b0;
    rst_ni = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, '0, "R2 empty after release");
  endtask

  task automatic t_order();
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 1'b0, 9'(i * 83 + 256), "R1 R5 write");
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 1'b0, '0, "R1 R5 ordered read");
    cyc(1'b0, 1'b0, 1'b0, '0, "R9 hold when idle");
  endtask

  task automatic t_underflow();
    cyc(1'b0, 1'b1, 1'b0, '0, "R3 read on empty");
    cyc(1'b0, 1'b1, 1'b0, '0, "R3 R9 repeated read on empty");
    cyc(1'b1, 1'b1, 1'b0, 9'h155, "R8 write+read on empty: write only");
    cyc(1'b0, 1'b1, 1'b0, '0, "R8 R1 read back");
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b0, 1'b0, 9'(i * 29 + 7), "R6 R7 fill");
    cyc(1'b1, 1'b0, 1'b0, 9'h0ff, "R3 write on full");
    cyc(1'b1, 1'b1, 1'b0, 9'h1ff, "R8 write+read on full: read only");
    cyc(1'b1, 1'b0, 1'b0, 9'h123, "R6 refill last slot");
    for (int i = 0; i < DEPTH; i++) cyc(1'b0, 1'b1, 1'b0, '0, "R1 R7 R5 drain");
  endtask

  task automatic t_simul();
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b0, 9'(i + 300), "R8 prefill");
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1, 1'b0, 9'(i * 51), "R8 write+read");
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b0, '0, "R8 R1 drain");
  endtask

  task automatic t_rewind();
    t_reset();
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 1'b0, 9'(i * 17 + 260), "R4 load");
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 1'b0, '0, "R4 partial read");
    cyc(1'b1, 1'b1, 1'b1, 9'h0aa, "R10 R4 rewind with strobes");
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1, 1'b0, '0, "R4 replay");
    cyc(1'b0, 1'b1, 1'b0, '0, "R4 empty after replay");
    cyc(1'b0, 1'b0, 1'b1, '0, "R4 rewind from empty");
    cyc(1'b0, 1'b1, 1'b0, '0, "R4 second replay first word");
    // rewind above half level restores the half flag
    t_reset();
    for (int i = 0; i < HALF + 1; i++) cyc(1'b1, 1'b0, 1'b0, 9'(i), "R7 load past half");
    cyc(1'b0, 1'b1, 1'b0, '0, "R7 back to half");
    cyc(1'b0, 1'b0, 1'b1, '0, "R4 R7 rewind restores level");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_underflow();
    t_fill();
    t_simul();
    t_rewind();
    summary();
    $finish;
  end
endmodule